// File: doc/BRIEF.md
# Serialized AXI4-Lite Manager with Request Queue

This block turns a local stream of read and write requests into AXI4-Lite transactions towards one subordinate. Each request carries a tag, a word-aligned address and, for writes, a data word and a "posted" marker. Requests of both kinds wait in one shared first-in-first-out queue. The block executes them strictly in arrival order, and only one bus transaction is ever outstanding. For every finished transaction the block emits a one-cycle completion that returns the tag, the kind, the posted marker, the read data and the 2-bit response code.

A write raises its address and data valids together, and each valid falls on its own handshake. The write is finished only by the response handshake. A read is finished by the read-data handshake. Both response-side ready signals stay high, and the write strobe always covers the whole word. A request whose address is not a whole multiple of the data width in bytes is dropped, and the block signals the drop with an error pulse. All outputs are registered.

Top module: `axl_serial_manager`

## Requirements
- R1: `cmd_ready` is high exactly when fewer than `DEPTH` requests wait in the queue. A request is taken on a cycle where `cmd_valid` and `cmd_ready` are both high.
- R2: A taken request whose address has any of its low log2(DATA_W/8) bits set never enters the queue and causes no bus activity. `cmd_misaligned` is high for exactly the one cycle after it was taken.
- R3: Queued operations start in arrival order, and no operation starts before the previous one has produced its completion. Completion tags therefore come back in issue order.
- R4: A read raises `m_arvalid` with the queued address. The address stays stable and the valid stays high until the cycle after the handshake on that channel, where the valid falls.
- R5: A write raises `m_awvalid` and `m_wvalid` in the same cycle, carrying the queued address and data. Each one stays high with a stable payload until its own handshake and falls on the following cycle.
- R6: `m_rready` and `m_bready` are always 1, and `m_wstrb` is always all ones.
- R7: The cycle after a read-data handshake during a read, `cpl_valid` is high for one cycle with the tag, `cpl_write`=0, `cpl_rdata` equal to the handshaken data, and `cpl_resp` equal to the read response.
- R8: A write completes only on the write-response handshake, not on the data handshake. Its completion has `cpl_write`=1, `cpl_rdata`=0, `cpl_resp` equal to the write response, and `cpl_posted` echoing the request's posted marker.
- R9: A request taken into an empty queue while the bus is idle has its valids visible two cycles after the cycle it was presented. A queued operation launches with valids visible in the cycle right after the previous completion's `cpl_valid` cycle.
- R10: A read-data or write-response valid that arrives while no operation of that kind is in flight produces no completion.
- R11: After reset, `cmd_ready` is high and every bus valid, `cpl_valid` and `cmd_misaligned` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Queue can take a request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_posted | input | 1 | Posted marker, echoed in completion |
| cmd_id | input | ID_W | Request tag |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | DATA_W | Write data |
| cmd_misaligned | output | 1 | One-cycle pulse for a dropped unaligned request |
| cpl_valid | output | 1 | Completion present (one cycle) |
| cpl_write | output | 1 | Completion kind, 1 = write |
| cpl_posted | output | 1 | Posted marker of the completed request |
| cpl_id | output | ID_W | Tag of the completed request |
| cpl_rdata | output | DATA_W | Read data (zero for writes) |
| cpl_resp | output | 2 | Read or write response code |
| m_araddr | output | ADDR_W | Read address |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready (constant 1) |
| m_awaddr | output | ADDR_W | Write address |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write strobes (all ones) |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready (constant 1) |

## Verification
The hardest state to reach from the ports is a full queue with one operation stuck on the bus. In that state `cmd_ready` has to fall, and it has to rise again in step with each completion. The bench reaches it by stalling every subordinate ready signal while it issues more than `DEPTH` mixed requests, then releasing the stall and comparing every cycle against its queue model. Randomised subordinate readies and response delays give each order of the write-address and write-data handshakes. A separate idle window drives unsolicited read-data and write-response valids to show that they produce no completion.

// File: rtl/axl_pkg.sv
package axl_pkg;

  typedef enum logic {
    KIND_READ  = 1'b0,
    KIND_WRITE = 1'b1
  } op_kind_e;

  // number of low address bits that must be zero for a full-word access
  function automatic int unsigned word_offset_bits(input int unsigned data_w);
    return (data_w == 64) ? 3 : 2;
  endfunction

endpackage

// File: rtl/axl_req_fifo.sv
module axl_req_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign dout  = store[rd_ptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty) else $error("pop from empty queue"); // R3

endmodule

// File: rtl/axl_rd_port.sv
module axl_rd_port #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] done_data,
  output logic [1:0]        done_resp,
  output logic [ADDR_W-1:0] araddr,
  output logic              arvalid,
  input  logic              arready,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp,
  input  logic              rvalid
);
  // event wires for the checks
  logic ar_hs;
  assign ar_hs     = arvalid && arready;
  assign done      = busy && rvalid;
  assign done_data = rdata;
  assign done_resp = rresp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      arvalid <= 1'b0;
      araddr  <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      arvalid <= 1'b1;
      araddr  <= start_addr;
    end else if (busy) begin
      if (ar_hs) arvalid <= 1'b0;
      if (done) begin
        busy    <= 1'b0;
        arvalid <= 1'b0;
      end
    end
  end

  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid && !arready && !rvalid |=> arvalid && $stable(araddr))
    else $error("read address dropped early"); // R4
  AST_AR_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ar_hs |=> !arvalid) else $error("read address valid after handshake"); // R4
  AST_RD_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy) else $error("read started while busy"); // R3

endmodule

// File: rtl/axl_wr_port.sv
module axl_wr_port #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_data,
  output logic              busy,
  output logic              done,
  output logic [1:0]        done_resp,
  output logic [ADDR_W-1:0] awaddr,
  output logic              awvalid,
  input  logic              awready,
  output logic [DATA_W-1:0] wdata,
  output logic              wvalid,
  input  logic              wready,
  input  logic [1:0]        bresp,
  input  logic              bvalid
);
  logic aw_hs, w_hs;
  assign aw_hs     = awvalid && awready;
  assign w_hs      = wvalid && wready;
  assign done      = busy && bvalid;
  assign done_resp = bresp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      awvalid <= 1'b0;
      wvalid  <= 1'b0;
      awaddr  <= '0;
      wdata   <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      awvalid <= 1'b1;
      wvalid  <= 1'b1;
      awaddr  <= start_addr;
      wdata   <= start_data;
    end else if (busy) begin
      if (aw_hs) awvalid <= 1'b0;
      if (w_hs)  wvalid  <= 1'b0;
      if (done) begin
        busy    <= 1'b0;
        awvalid <= 1'b0;
        wvalid  <= 1'b0;
      end
    end
  end

  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready && !bvalid |=> awvalid && $stable(awaddr))
    else $error("write address dropped early"); // R5
  AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready && !bvalid |=> wvalid && $stable(wdata))
    else $error("write data dropped early"); // R5
  AST_AW_W_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awvalid) |-> $rose(wvalid)) else $error("write valids split"); // R5
  AST_WR_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy) else $error("write started while busy"); // R3

endmodule

// File: rtl/axl_serial_manager.sv
module axl_serial_manager
  import axl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic              cmd_posted,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_misaligned,
  output logic              cpl_valid,
  output logic              cpl_write,
  output logic              cpl_posted,
  output logic [ID_W-1:0]   cpl_id,
  output logic [DATA_W-1:0] cpl_rdata,
  output logic [1:0]        cpl_resp,
  output logic [ADDR_W-1:0] m_araddr,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rvalid,
  output logic              m_rready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic [1:0]        m_bresp,
  input  logic              m_bvalid,
  output logic              m_bready
);
  localparam int STRB_W = DATA_W / 8;
  localparam int OFS_W  = int'(word_offset_bits(DATA_W));

  generate
    if (!(DATA_W == 32 || DATA_W == 64) || ADDR_W > 64 || ADDR_W <= OFS_W) begin : g_bad_cfg
      initial $fatal(1, "unsupported address or data width");
    end
  endgenerate

  typedef struct packed {
    logic              wr;
    logic              posted;
    logic [ID_W-1:0]   id;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } entry_t;

  function automatic logic word_aligned(input logic [ADDR_W-1:0] a);
    return (a[OFS_W-1:0] == '0);
  endfunction

  // ---------------- intake ----------------
  logic   take, push_evt, drop_evt;
  logic   q_full, q_empty, q_pop;
  entry_t q_in, q_head;

  assign cmd_ready = !q_full;
  assign take      = cmd_valid && cmd_ready;
  assign push_evt  = take && word_aligned(cmd_addr);
  assign drop_evt  = take && !word_aligned(cmd_addr);
  assign q_in      = '{wr: cmd_write, posted: cmd_posted, id: cmd_id,
                       addr: cmd_addr, data: cmd_wdata};

  axl_req_fifo #(.WIDTH($bits(entry_t)), .DEPTH(DEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_evt),
    .din   (q_in),
    .pop   (q_pop),
    .dout  (q_head),
    .full  (q_full),
    .empty (q_empty)
  );

  // ---------------- sequencing ----------------
  logic        rd_busy, wr_busy, rd_done, wr_done;
  logic        launch, start_rd, start_wr;
  logic [DATA_W-1:0] rd_data;
  logic [1:0]  rd_resp, wr_resp;
  logic [ID_W-1:0] cur_id;
  logic        cur_posted;
  op_kind_e    cur_kind;

  assign launch   = !rd_busy && !wr_busy && !q_empty;
  assign q_pop    = launch;
  assign start_rd = launch && !q_head.wr;
  assign start_wr = launch && q_head.wr;

  axl_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_rd),
    .start_addr (q_head.addr),
    .busy       (rd_busy),
    .done       (rd_done),
    .done_data  (rd_data),
    .done_resp  (rd_resp),
    .araddr     (m_araddr),
    .arvalid    (m_arvalid),
    .arready    (m_arready),
    .rdata      (m_rdata),
    .rresp      (m_rresp),
    .rvalid     (m_rvalid)
  );

  axl_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_wr),
    .start_addr (q_head.addr),
    .start_data (q_head.data),
    .busy       (wr_busy),
    .done       (wr_done),
    .done_resp  (wr_resp),
    .awaddr     (m_awaddr),
    .awvalid    (m_awvalid),
    .awready    (m_awready),
    .wdata      (m_wdata),
    .wvalid     (m_wvalid),
    .wready     (m_wready),
    .bresp      (m_bresp),
    .bvalid     (m_bvalid)
  );

  assign m_rready = 1'b1;
  assign m_bready = 1'b1;
  assign m_wstrb  = {STRB_W{1'b1}};

  // ---------------- completion and error ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_id         <= '0;
      cur_posted     <= 1'b0;
      cur_kind       <= KIND_READ;
      cmd_misaligned <= 1'b0;
      cpl_valid      <= 1'b0;
      cpl_write      <= 1'b0;
      cpl_posted     <= 1'b0;
      cpl_id         <= '0;
      cpl_rdata      <= '0;
      cpl_resp       <= '0;
    end else begin
      cmd_misaligned <= drop_evt;
      if (launch) begin
        cur_id     <= q_head.id;
        cur_posted <= q_head.posted;
        cur_kind   <= q_head.wr ? KIND_WRITE : KIND_READ;
      end
      cpl_valid <= rd_done || wr_done;
      if (rd_done || wr_done) begin
        cpl_id     <= cur_id;
        cpl_posted <= cur_posted;
        cpl_write  <= (cur_kind == KIND_WRITE);
        cpl_rdata  <= rd_done ? rd_data : '0;
        cpl_resp   <= rd_done ? rd_resp : wr_resp;
      end
    end
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_arvalid && (m_awvalid || m_wvalid))) else $error("two kinds in flight"); // R3
  AST_CPL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> !cpl_valid) else $error("completion longer than one cycle"); // R7
  AST_BUS_QUIET_AT_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> !m_arvalid && !m_awvalid && !m_wvalid)
    else $error("launch overlapped completion"); // R9
  AST_KIND_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> cur_kind == KIND_READ) else $error("read done on write op"); // R10
  AST_DROP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_misaligned |-> $past(cmd_valid && cmd_ready)) else $error("spurious drop pulse"); // R2

endmodule

// File: tb/tb_axl_serial_manager.sv
`timescale 1ns/1ps
module tb_axl_serial_manager;
  localparam int AW = 32, DW = 32, IW = 4, DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cmd_valid = 0, cmd_write = 0, cmd_posted = 0;
  logic [IW-1:0] cmd_id = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, cmd_misaligned;
  logic cpl_valid, cpl_write, cpl_posted;
  logic [IW-1:0] cpl_id;
  logic [DW-1:0] cpl_rdata;
  logic [1:0] cpl_resp;
  logic [AW-1:0] m_araddr, m_awaddr;
  logic m_arvalid, m_rready, m_awvalid, m_wvalid, m_bready;
  logic [DW-1:0] m_wdata;
  logic [DW/8-1:0] m_wstrb;
  logic m_arready = 0, m_rvalid = 0, m_awready = 0, m_wready = 0, m_bvalid = 0;
  logic [DW-1:0] m_rdata = '0;
  logic [1:0] m_rresp = '0, m_bresp = '0;

  axl_serial_manager #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_posted(cmd_posted), .cmd_id(cmd_id), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_misaligned(cmd_misaligned),
    .cpl_valid(cpl_valid), .cpl_write(cpl_write), .cpl_posted(cpl_posted),
    .cpl_id(cpl_id), .cpl_rdata(cpl_rdata), .cpl_resp(cpl_resp),
    .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready),
    .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready)
  );

  typedef struct packed {
    logic wr; logic posted; logic [IW-1:0] id; logic [AW-1:0] addr; logic [DW-1:0] data;
  } req_t;

  req_t stim[$];
  req_t mq[$];
  logic [IW-1:0] order_q[$];
  int checks = 0, fails = 0, cpl_seen = 0;
  bit stall = 0, stray = 0, gaps = 0, finished = 0;

  // reference model state
  bit busy_rd = 0, busy_wr = 0;
  req_t cur;
  bit e_ready = 1, e_err = 0, e_arv = 0, e_awv = 0, e_wv = 0, e_cpl = 0;
  bit p_arv = 0, p_awv = 0;
  logic [AW-1:0] e_addr = '0;
  logic [DW-1:0] e_wdata = '0, e_rdata = '0;
  bit e_cwr = 0, e_cpost = 0;
  logic [IW-1:0] e_cid = '0;
  logic [1:0] e_cresp = '0;

  // subordinate state
  bit s_r_have = 0, s_aw_have = 0, s_w_have = 0;
  int s_r_dly = 0, s_b_dly = 0;
  logic [AW-1:0] s_r_addr = '0, s_w_addr = '0;
  logic [DW-1:0] s_w_data = '0;

  function automatic logic [DW-1:0] sub_read(input logic [AW-1:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(cmd_ready == e_ready, "R1 cmd_ready", cmd_ready, e_ready);
    chk(cmd_misaligned == e_err, "R2 misaligned pulse", cmd_misaligned, e_err);
    chk(m_arvalid == e_arv, (e_arv && !p_arv) ? "R9 arvalid launch" : "R4 arvalid", m_arvalid, e_arv);
    if (e_arv) chk(m_araddr == e_addr, "R4 araddr", m_araddr, e_addr);
    chk(m_awvalid == e_awv, (e_awv && !p_awv) ? "R9 awvalid launch" : "R5 awvalid", m_awvalid, e_awv);
    chk(m_wvalid == e_wv, "R5 wvalid", m_wvalid, e_wv);
    if (e_awv) chk(m_awaddr == e_addr, "R5 awaddr", m_awaddr, e_addr);
    if (e_wv) chk(m_wdata == e_wdata, "R5 wdata", m_wdata, e_wdata);
    chk(m_rready && m_bready && (m_wstrb == 4'hF), "R6 constant readies/strobe",
        {m_rready, m_bready, m_wstrb}, 6'h3F);
    chk(cpl_valid == e_cpl, "R7/R8 cpl_valid", cpl_valid, e_cpl);
    if (cpl_valid) begin
      cpl_seen++;
      if (order_q.size() > 0) begin
        chk(cpl_id == order_q[0], "R3 completion order", cpl_id, order_q[0]);
        void'(order_q.pop_front());
      end else chk(0, "R3 completion with nothing issued", cpl_id, 0);
    end
    if (e_cpl) begin
      if (e_cwr) begin
        chk(cpl_write == 1 && cpl_rdata == 0, "R8 write kind/zero data", {cpl_write, cpl_rdata}, {1'b1, 32'h0});
        chk(cpl_posted == e_cpost, "R8 posted echo", cpl_posted, e_cpost);
        chk(cpl_resp == e_cresp, "R8 bresp", cpl_resp, e_cresp);
        chk(cpl_id == e_cid, "R8 id", cpl_id, e_cid);
      end else begin
        chk(cpl_write == 0, "R7 read kind", cpl_write, 0);
        chk(cpl_rdata == e_rdata, "R7 rdata", cpl_rdata, e_rdata);
        chk(cpl_resp == e_cresp, "R7 rresp", cpl_resp, e_cresp);
        chk(cpl_id == e_cid, "R7 id", cpl_id, e_cid);
      end
    end
    p_arv = e_arv;
    p_awv = e_awv;
  endtask

  task automatic step();
    int pre_len;
    bit present, aligned;
    @(negedge clk);
    compare();
    // request side
    present = (stim.size() > 0) && (!gaps || ($urandom_range(0, 3) != 0));
    cmd_valid = present;
    if (present) begin
      cmd_write = stim[0].wr; cmd_posted = stim[0].posted; cmd_id = stim[0].id;
      cmd_addr = stim[0].addr; cmd_wdata = stim[0].data;
    end
    // subordinate side
    m_arready = !stall && !s_r_have && ($urandom_range(0, 2) != 0);
    m_awready = !stall && !s_aw_have && ($urandom_range(0, 2) != 0);
    m_wready  = !stall && !s_w_have && ($urandom_range(0, 2) != 0);
    m_rvalid  = (s_r_have && s_r_dly == 0) || stray;
    m_rdata   = stray ? 32'hDEAD_BEEF : sub_read(s_r_addr);
    m_rresp   = stray ? 2'b11 : s_r_addr[5:4];
    m_bvalid  = (s_aw_have && s_w_have && s_b_dly == 0) || stray;
    m_bresp   = stray ? 2'b10 : (s_w_addr[5:4] ^ s_w_data[1:0]);
    // reference model for the coming edge
    pre_len = mq.size();
    e_cpl = 0;
    if (busy_rd) begin
      if (e_arv && m_arready) e_arv = 0;
      if (m_rvalid) begin
        e_cpl = 1; e_cwr = 0; e_cid = cur.id; e_cpost = cur.posted;
        e_rdata = m_rdata; e_cresp = m_rresp; busy_rd = 0; e_arv = 0;
      end
    end else if (busy_wr) begin
      if (e_awv && m_awready) e_awv = 0;
      if (e_wv && m_wready) e_wv = 0;
      if (m_bvalid) begin
        e_cpl = 1; e_cwr = 1; e_cid = cur.id; e_cpost = cur.posted;
        e_cresp = m_bresp; busy_wr = 0; e_awv = 0; e_wv = 0;
      end
    end else if (pre_len > 0) begin
      cur = mq.pop_front();
      e_addr = cur.addr;
      if (cur.wr) begin busy_wr = 1; e_awv = 1; e_wv = 1; e_wdata = cur.data; end
      else begin busy_rd = 1; e_arv = 1; end
    end
    aligned = (cmd_addr[1:0] == 2'b00);
    e_err = present && (pre_len < DEPTH) && !aligned;
    if (present && pre_len < DEPTH) begin
      if (aligned) begin
        mq.push_back(stim[0]);
        order_q.push_back(stim[0].id);
      end
      void'(stim.pop_front());
    end
    e_ready = (mq.size() < DEPTH);
    // subordinate state for the coming edge
    if (m_rvalid && s_r_have && s_r_dly == 0) s_r_have = 0;
    else if (s_r_have && s_r_dly > 0) s_r_dly--;
    if (m_arvalid && m_arready) begin s_r_have = 1; s_r_addr = m_araddr; s_r_dly = $urandom_range(0, 3); end
    if (m_bvalid && s_aw_have && s_w_have && s_b_dly == 0) begin s_aw_have = 0; s_w_have = 0; end
    else if (s_aw_have && s_w_have && s_b_dly > 0) s_b_dly--;
    if (m_awvalid && m_awready) begin s_aw_have = 1; s_w_addr = m_awaddr; s_b_dly = $urandom_range(0, 3); end
    if (m_wvalid && m_wready) begin s_w_have = 1; s_w_data = m_wdata; end
  endtask

  task automatic drain();
    while (stim.size() > 0 || mq.size() > 0 || busy_rd || busy_wr) step();
    repeat (3) step();
  endtask

  function automatic req_t mk(input bit wr, input bit posted, input int id,
                              input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_t r;
    r.wr = wr; r.posted = posted; r.id = IW'(id); r.addr = a; r.data = d;
    return r;
  endfunction

  initial begin
    int seen_before;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(cmd_ready == 1, "R11 ready after reset", cmd_ready, 1);
    chk(!m_arvalid && !m_awvalid && !m_wvalid, "R11 bus valids low", {m_arvalid, m_awvalid, m_wvalid}, 0);
    chk(!cpl_valid && !cmd_misaligned, "R11 completion/error low", {cpl_valid, cmd_misaligned}, 0);
    rst_n = 1'b1;

    // single read, then writes with and without posted marker (R7, R8, R9)
    stim.push_back(mk(0, 0, 1, 32'h0000_0110, '0));
    drain();
    stim.push_back(mk(1, 0, 2, 32'h0000_0220, 32'hA5A5_0001));
    stim.push_back(mk(1, 1, 3, 32'h0000_0330, 32'h5A5A_0002));
    drain();

    // R2: unaligned requests dropped between aligned ones
    stim.push_back(mk(1, 0, 4, 32'h0000_0102, 32'h1111_1111));
    stim.push_back(mk(0, 0, 5, 32'h0000_0101, '0));
    stim.push_back(mk(0, 1, 6, 32'h0000_0140, '0));
    stim.push_back(mk(1, 0, 7, 32'h0000_0003, 32'h2222_2222));
    drain();

    // R1: fill the queue behind a stalled subordinate
    stall = 1;
    for (int i = 0; i < 12; i++)
      stim.push_back(mk(i[0], i[1], i, 32'h0000_1000 + 32'(i * 16), 32'hC000_0000 + 32'(i)));
    repeat (30) step();
    chk(stim.size() == 3 && cmd_ready == 0, "R1 backpressure when full", {stim.size(), cmd_ready}, {32'd3, 1'b0});
    stall = 0;
    drain();

    // R10: unsolicited responses while idle
    seen_before = cpl_seen;
    stray = 1;
    repeat (6) step();
    stray = 0;
    repeat (3) step();
    chk(cpl_seen == seen_before, "R10 no completion from stray valids", cpl_seen, seen_before);

    // R3/R5: long random mix with gaps
    gaps = 1;
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      a = {18'h0, 10'($urandom), 4'h0};
      if ($urandom_range(0, 7) == 0) a[1:0] = 2'($urandom_range(1, 3));
      stim.push_back(mk($urandom_range(0, 1), $urandom_range(0, 1), i, a, $urandom));
    end
    drain();
    gaps = 0;
    chk(order_q.size() == 0, "R3 every issued request completed", order_q.size(), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R3 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule